// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block controls an external 10-bit successive-approximation converter that has a 16-way input multiplexer. Software programs it through two 8-bit control registers on a small synchronous CPU bus. The first control register holds a start request, an operating mode, an input-disable flag and a channel number. The second holds a reference-ladder policy and a conversion-time code. The block drives the channel number, the ladder enable and a 10-bit trial code for the external DAC. It then resolves the input by binary search against a one-bit comparator.

A conversion takes a selectable whole number of clock cycles. The ten bit decisions are spread evenly across that time. When a conversion ends, the code is latched into a result register, an end-of-conversion flag is set and a one-cycle interrupt pulse is raised. In single mode each start request yields one conversion. In repeat mode conversions follow each other with no gap until the mode is changed. A low-power request puts both control registers back to their reset values and abandons any conversion in flight.

Bus map: address 0 is control 1, address 1 is control 2, address 2 is result bits 9:2, and address 3 is status. The status byte has end-of-conversion in bit 7, busy in bit 6 and result bits 1:0 in bits 1:0.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, control 1 reads 0x10 (inputs disabled), control 2 reads 0x00, and busy, eoc, irq and ladder_en are all 0.
- R2: The mode field is control 1 bits 6:5. Code 01 gives one conversion per start. Code 11 restarts a new conversion in the same cycle the previous one completes, for as long as the field stays 11. Codes 00 and 10 never start a conversion.
- R3: Writing 1 to control 1 bit 7 launches a conversion on the next clock edge, and busy is high from that edge on. The bit then reads back as 0.
- R4: Control 1 bits 3:0 drive chan_sel directly, and the conversion resolves the comparator of the selected channel.
- R5: The search runs MSB first. At each decision the comparator is sampled: 1 keeps the trial bit and 0 clears it. The final 10-bit code reads back as {address 2, address 3 bits 1:0}. dac_code is 0 whenever busy is low.
- R6: Control 2 bits 3:1 select the conversion time: 000=39, 010=78, 011=156, 100=312, 101=624 and 110=1248 cycles. busy stays high for exactly that many cycles. Codes 001 and 111 start no conversion.
- R7: At completion eoc is set and irq is high for exactly one cycle. eoc stays set until address 2 is read with bus_rd.
- R8: A start request made while busy is high is ignored. The running conversion keeps its length, and no second conversion follows.
- R9: When control 2 bit 5 is 0, ladder_en is high only while busy is high. When it is 1, ladder_en is always high.
- R10: While sleep_req is high, both control registers go back to their reset values, busy drops, dac_code becomes 0 and no interrupt follows.
- R11: Control 2 bits 7:6 always read as 0, and bits 5:0 read back as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Low-power entry; resets the control registers and aborts the conversion |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears eoc on an address 2 read) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial code |
| chan_sel | output | 4 | Analog channel number |
| ain_off | output | 1 | Analog input disable |
| ladder_en | output | 1 | Reference ladder enable |
| dac_code | output | 10 | Trial code for the DAC |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End-of-conversion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A wrong step counter or latched period shows up as a busy window that is not exactly the selected length, or as an interrupt gap in repeat mode that differs from it. Both can be measured to the cycle within one conversion time. A faulty bit decision or mask shift makes the result differ from the modelled input level at the first completion. A start-gating fault shows as busy rising where it must not, within two cycles of the offending write. A reset or sleep fault shows at once in the register read-back and in ladder_en.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W    = 10;
    localparam int CH_W     = 4;
    localparam int BUS_W    = 8;
    localparam int BASE_CYC = 39;
    localparam int MAX_CYC  = BASE_CYC * 32;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int STEP_W   = $clog2(RES_W);
    localparam int PROD_W   = CNT_W + STEP_W + 1;

    localparam logic [1:0] ADDR_CTRL1  = 2'd0;
    localparam logic [1:0] ADDR_CTRL2  = 2'd1;
    localparam logic [1:0] ADDR_RES_HI = 2'd2;
    localparam logic [1:0] ADDR_STAT   = 2'd3;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_RSVD   = 2'b10,
        MODE_REPEAT = 2'b11
    } mode_e;

    typedef struct packed {
        logic              start;
        mode_e             mode;
        logic              ain_off;
        logic [CH_W-1:0]   chan;
    } ctrl1_t;

    typedef struct packed {
        logic        ladder_on;
        logic        fixed_one;
        logic [2:0]  tsel;
        logic        fixed_zero;
    } ctrl2_t;

    localparam ctrl1_t CTRL1_RST = '{start: 1'b0, mode: MODE_OFF,
                                     ain_off: 1'b1, chan: '0};
    localparam ctrl2_t CTRL2_RST = '{ladder_on: 1'b0, fixed_one: 1'b0,
                                     tsel: 3'b000, fixed_zero: 1'b0};

    // Cycles per conversion; zero marks a reserved code.
    function automatic logic [CNT_W-1:0] period_of(input logic [2:0] tsel);
        case (tsel)
            3'b000:  return CNT_W'(BASE_CYC);
            3'b010:  return CNT_W'(BASE_CYC * 2);
            3'b011:  return CNT_W'(BASE_CYC * 4);
            3'b100:  return CNT_W'(BASE_CYC * 8);
            3'b101:  return CNT_W'(BASE_CYC * 16);
            3'b110:  return CNT_W'(BASE_CYC * 32);
            default: return '0;
        endcase
    endfunction

    // Last cycle index of decision step k within a period of per cycles.
    function automatic logic [CNT_W-1:0] step_end(input logic [CNT_W-1:0] per,
                                                  input logic [STEP_W-1:0] k);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(per) * (PROD_W'(k) + PROD_W'(1));
        return CNT_W'(prod / PROD_W'(RES_W) - PROD_W'(1));
    endfunction

endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_req,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                busy,
    input  logic                eoc,
    input  logic [RES_W-1:0]    result,
    output ctrl1_t              c1,
    output ctrl2_t              c2,
    output logic                res_read
);

    localparam int HI_W = BUS_W;
    localparam int LO_W = RES_W - HI_W;

    always_ff @(posedge clk) begin
        if (rst || sleep_req) begin
            c1 <= CTRL1_RST;
            c2 <= CTRL2_RST;
        end else begin
            c1.start <= 1'b0;
            if (bus_wr && bus_addr == ADDR_CTRL1)
                c1 <= ctrl1_t'(bus_wdata);
            if (bus_wr && bus_addr == ADDR_CTRL2)
                c2 <= ctrl2_t'(bus_wdata[5:0]);
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL1:  bus_rdata = c1;
            ADDR_CTRL2:  bus_rdata = {2'b00, c2};
            ADDR_RES_HI: bus_rdata = result[RES_W-1 -: HI_W];
            default:     bus_rdata = {eoc, busy, {(BUS_W-2-LO_W){1'b0}}, result[LO_W-1:0]};
        endcase
    end

    assign res_read = bus_rd && (bus_addr == ADDR_RES_HI);

    a_r10_sleep_clears_regs: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> (c1 == CTRL1_RST && c2 == CTRL2_RST));

    a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (c1.start && !(bus_wr && bus_addr == ADDR_CTRL1)) |=> !c1.start);

endmodule

// File: rtl/adc_step_timer.sv
module adc_step_timer
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               abort,
    input  logic               launch,
    input  logic [CNT_W-1:0]   period_in,
    output logic               run,
    output logic               step_hit,
    output logic               final_hit,
    output logic [STEP_W-1:0]  step_idx
);

    logic [CNT_W-1:0] cyc;
    logic [CNT_W-1:0] per;

    assign step_hit  = run && (cyc == step_end(per, step_idx));
    assign final_hit = step_hit && (step_idx == STEP_W'(RES_W - 1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            run      <= 1'b0;
            cyc      <= '0;
            per      <= '0;
            step_idx <= '0;
        end else if (launch) begin
            run      <= 1'b1;
            cyc      <= '0;
            per      <= period_in;
            step_idx <= '0;
        end else if (run) begin
            cyc <= cyc + 1'b1;
            if (final_hit)
                run <= 1'b0;
            else if (step_hit)
                step_idx <= step_idx + 1'b1;
        end
    end

    a_r6_cycle_in_period: assert property (@(posedge clk) disable iff (rst)
        run |-> (cyc < per));

    a_r6_step_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (step_idx < STEP_W'(RES_W)));

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               abort,
    input  logic               launch,
    input  logic               step_hit,
    input  logic               final_hit,
    input  logic [STEP_W-1:0]  step_idx,
    input  logic               cmp_in,
    input  logic               res_read,
    output logic [RES_W-1:0]   trial,
    output logic [RES_W-1:0]   result,
    output logic               eoc,
    output logic               irq
);

    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] sel_mask;
    logic [RES_W-1:0] resolved;

    assign sel_mask = TOP_BIT >> step_idx;
    assign resolved = cmp_in ? trial : (trial & ~sel_mask);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            trial <= '0;
        end else if (launch) begin
            trial <= TOP_BIT;
        end else if (final_hit) begin
            trial <= '0;
        end else if (step_hit) begin
            trial <= resolved | (sel_mask >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            eoc    <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= final_hit && !abort;
            if (final_hit && !abort) begin
                result <= resolved;
                eoc    <= 1'b1;
            end else if (res_read) begin
                eoc <= 1'b0;
            end
        end
    end

    a_r7_irq_single_cycle: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r7_irq_with_eoc: assert property (@(posedge clk) disable iff (rst)
        irq |-> eoc);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [1:0]         bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic               cmp_in,
    output logic [3:0]         chan_sel,
    output logic               ain_off,
    output logic               ladder_en,
    output logic [9:0]         dac_code,
    output logic               busy,
    output logic               eoc,
    output logic               irq
);

    ctrl1_t            c1;
    ctrl2_t            c2;
    logic              res_read;
    logic [RES_W-1:0]  result;
    logic              run;
    logic              step_hit;
    logic              final_hit;
    logic [STEP_W-1:0] step_idx;
    logic [CNT_W-1:0]  period;
    logic              mode_ok;
    logic              launch;

    assign period  = period_of(c2.tsel);
    assign mode_ok = (c1.mode == MODE_SINGLE || c1.mode == MODE_REPEAT) && (period != '0);
    assign launch  = !sleep_req && mode_ok &&
                     ((c1.start && !run) || (final_hit && c1.mode == MODE_REPEAT));

    adc_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (run),
        .eoc       (eoc),
        .result    (result),
        .c1        (c1),
        .c2        (c2),
        .res_read  (res_read)
    );

    adc_step_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .abort     (sleep_req),
        .launch    (launch),
        .period_in (period),
        .run       (run),
        .step_hit  (step_hit),
        .final_hit (final_hit),
        .step_idx  (step_idx)
    );

    adc_sar_core u_sar (
        .clk       (clk),
        .rst       (rst),
        .abort     (sleep_req),
        .launch    (launch),
        .step_hit  (step_hit),
        .final_hit (final_hit),
        .step_idx  (step_idx),
        .cmp_in    (cmp_in),
        .res_read  (res_read),
        .trial     (dac_code),
        .result    (result),
        .eoc       (eoc),
        .irq       (irq)
    );

    assign busy      = run;
    assign chan_sel  = c1.chan;
    assign ain_off   = c1.ain_off;
    assign ladder_en = c2.ladder_on | run;

    a_r2_start_needs_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(c1.mode) == MODE_SINGLE || $past(c1.mode) == MODE_REPEAT));

    a_r10_sleep_aborts: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> (!busy && !irq));

    a_r5_dac_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dac_code == '0));

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic [3:0] chan_sel;
    logic       ain_off;
    logic       ladder_en;
    logic [9:0] dac_code;
    logic       busy;
    logic       eoc;
    logic       irq;

    logic [9:0] vin [16];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // Analog model: comparator of the selected channel against the DAC code.
    assign cmp_in = (vin[chan_sel] >= dac_code);

    adc_seq_ctrl u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .chan_sel(chan_sel), .ain_off(ain_off), .ladder_en(ladder_en),
        .dac_code(dac_code), .busy(busy), .eoc(eoc), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle_watch(input int n, output int busy_cnt, output int irq_cnt);
        busy_cnt = 0; irq_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy) busy_cnt++;
            if (irq) irq_cnt++;
        end
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 5000);
    endtask

    task automatic check_result(input string req, input int exp);
        logic [7:0] st, hi;
        peek(2'd3, st);
        chk({req, " eoc set"}, int'(st[7]), 1);
        rd(2'd2, hi);
        chk({req, " result"}, int'({hi, st[1:0]}), exp);
        peek(2'd3, st);
        chk("R7 eoc cleared by result read", int'(st[7]), 0);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        peek(2'd0, d); chk("R1 ctrl1 reset", int'(d), 16);
        peek(2'd1, d); chk("R1 ctrl2 reset", int'(d), 0);
        chk("R1 busy reset", int'(busy), 0);
        chk("R1 eoc reset", int'(eoc), 0);
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 ladder_en reset", int'(ladder_en), 0);
        chk("R1 ain_off reset", int'(ain_off), 1);
    endtask

    task automatic t_single(input logic [3:0] ch, input logic [9:0] val,
                            input logic [2:0] tsel, input int per);
        logic [7:0] d;
        int n, irqs;
        vin[ch] = val;
        wr(2'd1, 8'h10 | {4'd0, tsel, 1'b0});
        wr(2'd0, 8'h20 | {4'd0, ch});
        chk("R4 chan_sel follows ctrl1", int'(chan_sel), int'(ch));
        wr(2'd0, 8'hA0 | {4'd0, ch});
        @(negedge clk);
        chk("R3 busy after start", int'(busy), 1);
        peek(2'd0, d);
        chk("R3 start bit self-clears", int'(d[7]), 0);
        chk("R9 ladder on while busy", int'(ladder_en), 1);
        n = 1; irqs = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            if (busy) n++;
            if (irq) irqs++;
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (irq) irqs++;
        end
        chk("R6 busy length", n, per);
        chk("R7 one irq pulse", irqs, 1);
        chk("R9 ladder off when idle", int'(ladder_en), 0);
        chk("R5 dac zero when idle", int'(dac_code), 0);
        check_result("R5 R4", int'(val));
    endtask

    task automatic t_no_start;
        int b, q;
        vin[2] = 10'd500;
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h82);
        idle_watch(20, b, q);
        chk("R2 mode 00 starts nothing", b, 0);
        wr(2'd0, 8'hC2);
        idle_watch(20, b, q);
        chk("R2 mode 10 starts nothing", b, 0);
        wr(2'd1, 8'h12);
        wr(2'd0, 8'hA2);
        idle_watch(20, b, q);
        chk("R6 time code 001 starts nothing", b, 0);
        wr(2'd1, 8'h1E);
        wr(2'd0, 8'hA2);
        idle_watch(20, b, q);
        chk("R6 time code 111 starts nothing", b + q, 0);
    endtask

    task automatic t_start_while_busy;
        int n, irqs, b, q;
        vin[7] = 10'h0C8;
        wr(2'd1, 8'h10);
        wr(2'd0, 8'hA7);
        n = 0; irqs = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (busy) n++;
        end
        wr(2'd0, 8'hA7);
        n += 2;
        while (busy && n < 3000) begin
            @(negedge clk);
            if (busy) n++;
            if (irq) irqs++;
        end
        chk("R8 length kept despite start", n, 39);
        idle_watch(45, b, q);
        chk("R8 no second conversion", b, 0);
        chk("R8 single irq", irqs + q, 1);
        check_result("R8", 10'h0C8);
    endtask

    task automatic t_repeat;
        logic [7:0] st, hi;
        int n, b, q;
        vin[5] = 10'h1C3;
        wr(2'd1, 8'h10);
        wr(2'd0, 8'hE5);
        wait_irq(n);
        wait_irq(n);
        chk("R2 repeat irq spacing", n, 39);
        chk("R2 repeat keeps busy", int'(busy), 1);
        vin[5] = 10'h0F0;
        peek(2'd3, st);
        rd(2'd2, hi);
        chk("R2 repeat first result", int'({hi, st[1:0]}), 10'h1C3);
        wait_irq(n);
        peek(2'd3, st);
        rd(2'd2, hi);
        chk("R2 repeat tracks new input", int'({hi, st[1:0]}), 10'h0F0);
        wr(2'd0, 8'h25);
        wait_irq(n);
        idle_watch(45, b, q);
        chk("R2 repeat stops in single mode", b, 0);
    endtask

    task automatic t_ladder;
        logic [7:0] d;
        wr(2'd1, 8'hFF);
        peek(2'd1, d);
        chk("R11 ctrl2 upper bits read 0", int'(d), 8'h3F);
        chk("R9 ladder always on", int'(ladder_en), 1);
        chk("R9 idle while ladder on", int'(busy), 0);
        wr(2'd1, 8'h10);
        peek(2'd1, d);
        chk("R11 ctrl2 readback", int'(d), 8'h10);
        chk("R9 ladder off again", int'(ladder_en), 0);
    endtask

    task automatic t_sleep;
        logic [7:0] d;
        int b, q;
        vin[9] = 10'h155;
        wr(2'd1, 8'h3C);
        wr(2'd0, 8'hA9);
        for (int i = 0; i < 50; i++) @(negedge clk);
        chk("R10 running before sleep", int'(busy), 1);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R10 busy aborted", int'(busy), 0);
        chk("R10 dac cleared", int'(dac_code), 0);
        chk("R10 ladder off", int'(ladder_en), 0);
        peek(2'd0, d); chk("R10 ctrl1 reset", int'(d), 16);
        peek(2'd1, d); chk("R10 ctrl2 reset", int'(d), 0);
        idle_watch(30, b, q);
        chk("R10 no irq after abort", b + q, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) vin[i] = 10'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single(4'd3, 10'h2A5, 3'b000, 39);
        t_single(4'd12, 10'h3FF, 3'b010, 78);
        t_single(4'd0, 10'h000, 3'b011, 156);
        t_single(4'd14, 10'h201, 3'b100, 312);
        t_single(4'd9, 10'h155, 3'b110, 1248);
        t_no_start();
        t_start_while_busy();
        t_repeat();
        t_ladder();
        t_sleep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule